// File: doc/BRIEF.md
# Handshake Bus Bridge for a 128-bit Cipher Core

This block sits between a slow external controller and a 128-bit block-cipher engine. The two sides share no clock. They meet on a 16-bit bus that carries data both ways. Every transfer on that bus is a four-phase request/acknowledge exchange. The request, write-enable and read-enable lines are each resynchronised through two flops before any logic uses them.

Inbound, the bridge gathers eight 16-bit writes into four 32-bit buffer words. Once the eighth halfword is in, it presents the whole 128-bit block to the cipher and pulses a start strobe once. When the cipher signals completion, the bridge loads its 128-bit result in one step. It then hands that result back one halfword per read request, and drives the bus only while a read is being acknowledged. After the eighth halfword has been read, it returns to accepting writes.

The pad itself sits outside the block. The bridge provides the outgoing data and an output enable, and it receives the incoming bus value.

Top module: `cbb_bridge`

## Requirements
- R1: While reset is asserted and right after it, the acknowledge, output enable and start strobe are all low.
- R2: An acknowledge rises only after a request has been seen. It stays high as long as the request is held, and falls only after the request has been released.
- R3: Halfword k (k = 0..7, counted from the first write of a block) lands in blk_o[127-16k -: 16]. The first halfword of each 32-bit word therefore fills its upper half, and word 0 occupies blk_o[127:96].
- R4: The start strobe is high for exactly one clock cycle per block, and only after the eighth halfword is captured. After seven halfwords it has not fired.
- R5: The result is loaded in full when done_i is high. Read n (n = 0..7) returns res_i[127-16n -: 16], as captured at that load.
- R6: A read request made after a block is complete but before done_i stays unacknowledged until the result has been loaded. It is then acknowledged with halfword 0.
- R7: A read request made while an inbound block is still incomplete is never acknowledged.
- R8: The output enable is high only while a read acknowledge is high, and it is low again once that acknowledge drops.
- R9: After the eighth halfword has been read, the bridge accepts a new inbound block. The next result is returned starting from halfword 0.
- R10: A write request made while a result is pending or being returned is not acknowledged, and it leaves the returned data unchanged.
- R11: Because of the input synchronisers, the acknowledge is still low two clock edges after the request rises. It is high after the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bridge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transfer request from the controller (asynchronous) |
| wr_en_i | input | 1 | Marks the transfer as a write (asynchronous) |
| rd_en_i | input | 1 | Marks the transfer as a read (asynchronous) |
| bus_i | input | 16 | Value seen on the shared bus |
| bus_o | output | 16 | Value driven onto the shared bus during reads |
| bus_oe_o | output | 1 | Output enable for the bus pad; low means released |
| ack_o | output | 1 | Transfer acknowledge to the controller |
| blk_o | output | 128 | Assembled block for the cipher core |
| start_o | output | 1 | One-cycle start strobe for the cipher core |
| res_i | input | 128 | Result block from the cipher core |
| done_i | input | 1 | Result valid from the cipher core |

## Verification
The bench targets the points where the handshake could be acknowledged at the wrong time. These are:
- a read arriving mid-block, which a careless design would answer with stale data;
- a read arriving while the cipher is still busy, which would return the old result;
- a write during readout, which would corrupt the next block or shift the halfword counter.

The bench checks the halfword-to-bit placement against the block seen at the start strobe. It also counts start strobes, so that an early, doubled or missing start is exposed. Finally, it runs back-to-back blocks, so that a read counter that does not clear would return the second result out of order.

// File: rtl/cbb_pkg.sv
package cbb_pkg;
  typedef enum logic [1:0] {
    PH_IN  = 2'd0,
    PH_RUN = 2'd1,
    PH_OUT = 2'd2
  } phase_e;
endpackage

// File: rtl/cbb_sync2.sv
module cbb_sync2 #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/cbb_in_ctrl.sv
module cbb_in_ctrl #(
  parameter int HALF_W  = 16,
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_stb_i,
  input  logic [HALF_W-1:0]          half_i,
  output logic                       last_o,
  output logic [N_WORDS*WORD_W-1:0]  blk_o
);
  localparam int HPW    = WORD_W / HALF_W;
  localparam int N_HALF = N_WORDS * HPW;
  localparam int BLK_W  = N_WORDS * WORD_W;
  localparam int CNT_W  = $clog2(N_HALF);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (wr_stb_i) cnt_q <= last_o ? '0 : cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == CNT_W'(N_HALF - 1));

  // word buffers; first halfword of a word goes to its upper half
  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    for (genvar h = 0; h < HPW; h++) begin : g_half
      localparam int K = w * HPW + h;
      logic [HALF_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else if (wr_stb_i && cnt_q == CNT_W'(K)) q <= half_i;
      end
      assign blk_o[BLK_W-1-K*HALF_W -: HALF_W] = q;
    end
  end

  a_r4_count_wraps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_i && last_o) |=> (cnt_q == '0));
endmodule

// File: rtl/cbb_out_ctrl.sv
module cbb_out_ctrl #(
  parameter int HALF_W  = 16,
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       load_i,
  input  logic [N_WORDS*WORD_W-1:0]  res_i,
  input  logic                       adv_i,
  output logic [HALF_W-1:0]          half_o,
  output logic                       last_o
);
  localparam int HPW    = WORD_W / HALF_W;
  localparam int N_HALF = N_WORDS * HPW;
  localparam int BLK_W  = N_WORDS * WORD_W;
  localparam int CNT_W  = $clog2(N_HALF);

  logic [BLK_W-1:0] res_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      res_q <= res_i;
      cnt_q <= '0;
    end else if (adv_i) begin
      cnt_q <= last_o ? '0 : cnt_q + 1'b1;
    end
  end

  assign last_o = (cnt_q == CNT_W'(N_HALF - 1));
  assign half_o = res_q[BLK_W-1-int'(cnt_q)*HALF_W -: HALF_W];

  a_r9_cnt_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && last_o) |=> (cnt_q == '0));
  a_r5_no_load_mid_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && adv_i));
endmodule

// File: rtl/cbb_seq.sv
module cbb_seq
  import cbb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_s_i,
  input  logic wr_s_i,
  input  logic rd_s_i,
  input  logic in_last_i,
  input  logic out_last_i,
  input  logic done_i,
  output logic wr_stb_o,
  output logic rd_adv_o,
  output logic load_o,
  output logic start_o,
  output logic ack_o,
  output logic oe_o
);
  phase_e ph_q;
  logic   ack_q, oe_q, start_q;
  logic   rd_go, ack_clr;

  assign wr_stb_o = !ack_q && req_s_i && wr_s_i && ph_q == PH_IN;
  assign rd_go    = !ack_q && req_s_i && !wr_s_i && rd_s_i && ph_q == PH_OUT;
  assign ack_clr  = ack_q && !req_s_i;
  assign rd_adv_o = ack_clr && oe_q;
  assign load_o   = ph_q == PH_RUN && done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_IN;
      ack_q   <= 1'b0;
      oe_q    <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= wr_stb_o && in_last_i;
      if (wr_stb_o || rd_go) ack_q <= 1'b1;
      else if (ack_clr)      ack_q <= 1'b0;
      if (rd_go)        oe_q <= 1'b1;
      else if (ack_clr) oe_q <= 1'b0;
      unique case (ph_q)
        PH_IN:   if (wr_stb_o && in_last_i) ph_q <= PH_RUN;
        PH_RUN:  if (done_i) ph_q <= PH_OUT;
        PH_OUT:  if (rd_adv_o && out_last_i) ph_q <= PH_IN;
        default: ph_q <= PH_IN;
      endcase
    end
  end

  assign ack_o   = ack_q;
  assign oe_o    = oe_q;
  assign start_o = start_q;

  a_r2_ack_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_q) |-> $past(req_s_i));
  a_r2_ack_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_q && req_s_i) |=> ack_q);
  a_r4_start_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |=> !start_q);
  a_r8_oe_under_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q |-> ack_q);
  a_r6_read_needs_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) |-> ph_q == PH_OUT);
  a_r10_write_only_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ack_q) && !oe_q) |-> $past(ph_q) == PH_IN);
  a_r9_back_to_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_adv_o && out_last_i) |=> ph_q == PH_IN);
endmodule

// File: rtl/cbb_bridge.sv
module cbb_bridge #(
  parameter int HALF_W  = 16,
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 4,
  localparam int BLK_W  = N_WORDS * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [HALF_W-1:0] bus_i,
  output logic [HALF_W-1:0] bus_o,
  output logic              bus_oe_o,
  output logic              ack_o,
  output logic [BLK_W-1:0]  blk_o,
  output logic              start_o,
  input  logic [BLK_W-1:0]  res_i,
  input  logic              done_i
);
  logic [2:0]        ctl_s;
  logic              wr_stb, rd_adv, load, in_last, out_last;
  logic [HALF_W-1:0] out_half;

  cbb_sync2 #(.W(3)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({req_i, wr_en_i, rd_en_i}),
    .q_o   (ctl_s)
  );

  cbb_in_ctrl #(.HALF_W(HALF_W), .WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_in (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_stb_i(wr_stb),
    .half_i  (bus_i),
    .last_o  (in_last),
    .blk_o   (blk_o)
  );

  cbb_out_ctrl #(.HALF_W(HALF_W), .WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .res_i (res_i),
    .adv_i (rd_adv),
    .half_o(out_half),
    .last_o(out_last)
  );

  cbb_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_s_i   (ctl_s[2]),
    .wr_s_i    (ctl_s[1]),
    .rd_s_i    (ctl_s[0]),
    .in_last_i (in_last),
    .out_last_i(out_last),
    .done_i    (done_i),
    .wr_stb_o  (wr_stb),
    .rd_adv_o  (rd_adv),
    .load_o    (load),
    .start_o   (start_o),
    .ack_o     (ack_o),
    .oe_o      (bus_oe_o)
  );

  assign bus_o = bus_oe_o ? out_half : '0;

  a_r1_quiet_after_reset: assert property (@(posedge clk_i)
    !rst_ni |=> (!ack_o && !bus_oe_o && !start_o));
endmodule

// File: tb/cbb_bridge_tb.sv
module cbb_bridge_tb_top;
  localparam int CLK_PERIOD = 10;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_i = 1'b0, wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [15:0]  bus_i = '0;
  logic [15:0]  bus_o;
  logic         bus_oe_o, ack_o, start_o;
  logic [127:0] blk_o;
  logic [127:0] res_i = '0;
  logic         done_i = 1'b0;

  int n_chk = 0, n_fail = 0;
  int start_cnt = 0;
  int stub_delay = 5, stub_cnt = 0;
  bit stub_busy = 0;
  logic [127:0] seen_blk = '0, stub_res = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cbb_bridge dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i), .bus_i(bus_i), .bus_o(bus_o), .bus_oe_o(bus_oe_o),
    .ack_o(ack_o), .blk_o(blk_o), .start_o(start_o), .res_i(res_i),
    .done_i(done_i)
  );

  function automatic logic [127:0] cipher_f(input logic [127:0] b);
    return {b[63:0], b[127:64]} ^ 128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0;
  endfunction

  // cipher stub
  always @(negedge clk_i) begin
    done_i = 1'b0;
    if (start_o) begin
      start_cnt++;
      seen_blk  = blk_o;
      stub_res  = cipher_f(blk_o);
      stub_busy = 1;
      stub_cnt  = stub_delay;
    end else if (stub_busy) begin
      if (stub_cnt == 0) begin
        done_i = 1'b1; res_i = stub_res; stub_busy = 0;
      end else stub_cnt--;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_ack(input logic v, input string tag);
    int t = 0;
    while (ack_o !== v && t < 300) begin @(negedge clk_i); t++; end
    chk(ack_o === v, tag, ack_o, v);
  endtask

  task automatic put_half(input logic [15:0] d, input bit chk_sync);
    @(negedge clk_i);
    bus_i = d; wr_en_i = 1; rd_en_i = 0; req_i = 1;
    if (chk_sync) begin
      @(negedge clk_i); @(negedge clk_i);
      chk(ack_o === 1'b0, "R11 ack low after two edges", ack_o, 0);
      @(negedge clk_i);
      chk(ack_o === 1'b1, "R11 ack high after third edge", ack_o, 1);
    end
    wait_ack(1, "R2 write ack rise");
    repeat (3) @(negedge clk_i);
    chk(ack_o === 1'b1, "R2 ack held with req", ack_o, 1);
    req_i = 0;
    wait_ack(0, "R2 write ack fall");
    wr_en_i = 0;
  endtask

  task automatic get_half(output logic [15:0] d);
    @(negedge clk_i);
    rd_en_i = 1; req_i = 1;
    wait_ack(1, "R5 read ack rise");
    chk(bus_oe_o === 1'b1, "R8 oe during read ack", bus_oe_o, 1);
    d = bus_o;
    req_i = 0;
    wait_ack(0, "R2 read ack fall");
    chk(bus_oe_o === 1'b0, "R8 oe released", bus_oe_o, 0);
    rd_en_i = 0;
  endtask

  task automatic stray_req(input bit is_wr, input string tag);
    @(negedge clk_i);
    bus_i = 16'hDEAD; wr_en_i = is_wr; rd_en_i = !is_wr; req_i = 1;
    repeat (20) @(negedge clk_i);
    chk(ack_o === 1'b0 && bus_oe_o === 1'b0, tag, {ack_o, bus_oe_o}, 0);
    req_i = 0; wr_en_i = 0; rd_en_i = 0;
    repeat (4) @(negedge clk_i);
  endtask

  function automatic logic [15:0] hw(input logic [127:0] b, input int k);
    return b[127-16*k -: 16];
  endfunction

  task automatic t_reset();
    rst_ni = 0;
    repeat (3) @(negedge clk_i);
    chk(!ack_o && !bus_oe_o && !start_o, "R1 outputs idle in reset", {ack_o, bus_oe_o, start_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);
    chk(!ack_o && !bus_oe_o && !start_o, "R1 outputs idle after reset", {ack_o, bus_oe_o, start_o}, 0);
  endtask

  task automatic t_first_block();
    logic [127:0] exp_blk = 128'h1111_2222_3333_4444_5555_6666_7777_8888;
    logic [15:0] d;
    int s0 = start_cnt;
    stub_delay = 5;
    for (int k = 0; k < 8; k++) begin
      put_half(hw(exp_blk, k), k == 0);
      if (k == 2) stray_req(0, "R7 read mid-block not acked");
      if (k == 6) begin
        repeat (3) @(negedge clk_i);
        chk(start_cnt == s0, "R4 no start after seven", start_cnt - s0, 0);
      end
    end
    repeat (30) @(negedge clk_i);
    chk(start_cnt - s0 == 1, "R4 one start per block", start_cnt - s0, 1);
    chk(seen_blk == exp_blk, "R3 halfword placement", seen_blk, exp_blk);
    for (int k = 0; k < 8; k++) begin
      get_half(d);
      chk(d == hw(cipher_f(exp_blk), k), "R5 read order", d, hw(cipher_f(exp_blk), k));
    end
  endtask

  task automatic t_early_read();
    logic [127:0] exp_blk = 128'hA0A1_B2B3_C4C5_D6D7_E8E9_FAFB_0C0D_1E1F;
    logic [127:0] exp_res = cipher_f(exp_blk);
    logic [15:0] d;
    int s0 = start_cnt;
    stub_delay = 40;
    for (int k = 0; k < 8; k++) put_half(hw(exp_blk, k), 0);
    @(negedge clk_i);
    rd_en_i = 1; req_i = 1;
    repeat (15) @(negedge clk_i);
    chk(ack_o === 1'b0, "R6 read held before done", ack_o, 0);
    wait_ack(1, "R6 read acked after done");
    d = bus_o;
    chk(d == hw(exp_res, 0), "R9 second result starts at halfword 0", d, hw(exp_res, 0));
    req_i = 0;
    wait_ack(0, "R2 read ack fall");
    rd_en_i = 0;
    get_half(d);
    chk(d == hw(exp_res, 1), "R5 halfword 1", d, hw(exp_res, 1));
    stray_req(1, "R10 write during readout not acked");
    for (int k = 2; k < 8; k++) begin
      get_half(d);
      chk(d == hw(exp_res, k), "R10 readout intact after stray write", d, hw(exp_res, k));
    end
    chk(start_cnt - s0 == 1, "R4 one start second block", start_cnt - s0, 1);
  endtask

  task automatic t_third_block();
    logic [127:0] exp_blk = 128'h0001_0203_0405_0607_0809_0A0B_0C0D_0E0F;
    logic [15:0] d;
    stub_delay = 2;
    for (int k = 0; k < 8; k++) put_half(hw(exp_blk, k), 0);
    repeat (20) @(negedge clk_i);
    chk(seen_blk == exp_blk, "R9 new block accepted after readout", seen_blk, exp_blk);
    for (int k = 0; k < 8; k++) begin
      get_half(d);
      chk(d == hw(cipher_f(exp_blk), k), "R9 third result order", d, hw(cipher_f(exp_blk), k));
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    t_reset();
    t_first_block();
    t_early_read();
    t_third_block();
    repeat (5) @(negedge clk_i);
    finish_run();
  end
endmodule